// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Sequencer

This block masters the strobe lines of a parallel, self-timed EEPROM on behalf of a requester that wants single bytes written. A request carries an address and a data byte. The sequencer accepts it through a valid/ready handshake. It then drives chip enable, output enable, write enable, the address bus and the data bus with its drive enable. The strobe and the data are placed so that the setup, pulse-width and hold limits are met. Each limit is a count of system clocks, set by a parameter.

After the strobe, the device programs itself internally for an unknown time. The sequencer finds the end of that time in one of two ways, picked per request by a mode input. In polling mode it reads back the same address until the top data bit equals the top bit of the byte just written. In line mode it watches the open-drain ready/busy line until the line is released high. A timeout counter limits the wait. The sequencer ends each request with a one-cycle done pulse or a one-cycle timeout pulse. Only after that pulse does it accept the next request.

Top module: `eeprom_wr_seq`

## Requirements
- R1: After reset, the chip enable, output enable and write enable outputs are high, the data drive enable is low, ready is high, and neither the done pulse nor the timeout pulse is asserted.
- R2: A request is taken only on a clock edge where ready and valid are both high. Ready then stays low until the cycle of the done or timeout pulse, so a valid held high throughout produces exactly one write strobe for each request.
- R3: Chip enable is low, output enable is high, and the address and data are driven for exactly T_SETUP clocks before write enable falls.
- R4: Write enable stays low for exactly T_PULSE clocks. T_PULSE must lie between PULSE_MIN and PULSE_MAX, and this is checked at elaboration.
- R5: After write enable rises, data stays driven and chip enable stays low for exactly T_DHOLD clocks.
- R6: The address bus holds the request address without change from acceptance until the done or timeout pulse.
- R7: The data drive enable is never high while output enable is low. At least one clock with both released lies between the end of the write and the first read.
- R8: In polling mode (mode input = 1), each read holds chip enable and output enable low for T_RD clocks at the written address, and the data are sampled on the last of those clocks. The write is complete when data bit DW-1 (bit 7 for 8-bit data) equals the same bit of the written byte. Between reads, output enable goes high for at least one clock.
- R9: In line mode (mode input = 0), no read is issued. The sequencer waits T_BUSY clocks after the write, then signals done on the first cycle that the synchronised ready/busy line is high.
- R10: If the write has not completed about T_TIMEOUT clocks after the wait begins, the timeout pulse is raised instead of done. The pulse comes no earlier than T_TIMEOUT clocks and at most a few phase lengths later.
- R11: Done and timeout are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | AW | Byte address to write |
| req_data | input | DW | Byte to write |
| req_poll | input | 1 | Completion mode: 1 = read-back polling, 0 = ready/busy line |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| done_o | output | 1 | One-cycle pulse: write completed |
| timeout_o | output | 1 | One-cycle pulse: completion not seen in time |
| mem_ce_n | output | 1 | Chip enable to the memory, active low |
| mem_oe_n | output | 1 | Output enable to the memory, active low |
| mem_we_n | output | 1 | Write enable to the memory, active low |
| mem_addr | output | AW | Address bus |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DW | Data read back from the memory |
| mem_rdy | input | 1 | Ready/busy line from the memory, high when ready |

## Verification
A wrong phase count shows up as a mismatch in the length of the strobe, of the setup window or of the hold window. This is visible at the pins within one transaction, before any completion is signalled. A wrong completion state shows up differently, depending on the case:
- A mode decoded the wrong way shows as read strobes in line mode, or as none in polling mode.
- A bad polling comparison shows as done arriving while the model memory is still busy, or as a timeout where a done was due.
- A bus-turnaround error shows on the first cycle that output enable falls while the data drive is still on.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_TURN  = 3'd4,
    ST_READ  = 3'd5,
    ST_BWAIT = 3'd6
  } seq_state_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eewr_cnt.sv
module eewr_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/eewr_sync.sv
module eewr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= RST_VAL;
        else     chain_q[0] <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/eewr_fsm.sv
module eewr_fsm
  import eewr_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int PW        = 8,
  parameter int TW        = 16,
  parameter int T_SETUP   = 2,
  parameter int T_PULSE   = 15,
  parameter int T_DHOLD   = 2,
  parameter int T_BUSY    = 6,
  parameter int T_RD      = 15,
  parameter int T_TIMEOUT = 150000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_poll,
  output logic          req_ready,
  output logic          done_o,
  output logic          timeout_o,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          rdy_sync,
  output logic          ph_load,
  output logic [PW-1:0] ph_val,
  input  logic          ph_zero,
  output logic          tmo_load,
  output logic [TW-1:0] tmo_val,
  output logic          tmo_dec,
  input  logic          tmo_zero
);

  localparam logic [PW-1:0] LD_SETUP = PW'(T_SETUP - 1);
  localparam logic [PW-1:0] LD_PULSE = PW'(T_PULSE - 1);
  localparam logic [PW-1:0] LD_DHOLD = PW'(T_DHOLD - 1);
  localparam logic [PW-1:0] LD_BUSY  = PW'(T_BUSY - 1);
  localparam logic [PW-1:0] LD_RD    = PW'(T_RD - 1);
  localparam logic [TW-1:0] LD_TMO   = TW'(T_TIMEOUT - 1);

  seq_state_t    state_q;
  logic [DW-1:0] data_q;
  logic          poll_q;
  logic          poll_match;

  assign poll_match = (mem_dq_in[DW-1] == data_q[DW-1]);
  assign tmo_val    = LD_TMO;

  // Phase and timeout counter control, decoded from the current state.
  always_comb begin
    ph_load  = 1'b0;
    ph_val   = '0;
    tmo_load = 1'b0;
    tmo_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ph_load = 1'b1;
          ph_val  = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (ph_zero) begin
          ph_load = 1'b1;
          ph_val  = LD_PULSE;
        end
      end
      ST_PULSE: begin
        if (ph_zero) begin
          ph_load = 1'b1;
          ph_val  = LD_DHOLD;
        end
      end
      ST_HOLD: begin
        if (ph_zero) tmo_load = 1'b1;
      end
      ST_TURN: begin
        tmo_dec = 1'b1;
        ph_load = 1'b1;
        ph_val  = poll_q ? LD_RD : LD_BUSY;
      end
      ST_READ:  tmo_dec = 1'b1;
      ST_BWAIT: tmo_dec = 1'b1;
      default: ;
    endcase
  end

  // Sequencer state and registered bus outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      data_q     <= '0;
      poll_q     <= 1'b0;
      req_ready  <= 1'b1;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            data_q     <= req_data;
            poll_q     <= req_poll;
            mem_addr   <= req_addr;
            mem_dq_out <= req_data;
            mem_dq_oe  <= 1'b1;
            mem_ce_n   <= 1'b0;
            mem_oe_n   <= 1'b1;
            req_ready  <= 1'b0;
            state_q    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (ph_zero) begin
            mem_we_n <= 1'b0;
            state_q  <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (ph_zero) begin
            mem_we_n <= 1'b1;
            state_q  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (ph_zero) begin
            mem_dq_oe <= 1'b0;
            mem_ce_n  <= 1'b1;
            state_q   <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (poll_q) begin
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            state_q  <= ST_READ;
          end else begin
            state_q  <= ST_BWAIT;
          end
        end
        ST_READ: begin
          if (ph_zero) begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            if (poll_match) begin
              done_o    <= 1'b1;
              req_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end else if (tmo_zero) begin
              timeout_o <= 1'b1;
              req_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              state_q   <= ST_TURN;
            end
          end
        end
        ST_BWAIT: begin
          if (ph_zero) begin
            if (rdy_sync) begin
              done_o    <= 1'b1;
              req_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end else if (tmo_zero) begin
              timeout_o <= 1'b1;
              req_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n)); // R7

  AST_STROBE_FRAME: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe)); // R3

  AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n)); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr)); // R6

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o)); // R11

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (done_o || timeout_o) |=> !(done_o || timeout_o)); // R11

  AST_READY_WITH_END: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> (done_o || timeout_o)); // R2

  AST_NO_READ_LINE_MODE: assert property (@(posedge clk) disable iff (rst)
    (!poll_q && !req_ready) |-> mem_oe_n); // R9

endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
  import eewr_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DW          = 8,
  parameter int T_SETUP     = 2,
  parameter int PULSE_MIN   = 10,
  parameter int PULSE_MAX   = 100,
  parameter int T_PULSE     = 15,
  parameter int T_DHOLD     = 2,
  parameter int T_BUSY      = 6,
  parameter int T_RD        = 15,
  parameter int T_TIMEOUT   = 150000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_poll,
  output logic          req_ready,
  output logic          done_o,
  output logic          timeout_o,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_rdy
);

  localparam int PH_MAX = max_of(max_of(max_of(T_SETUP, T_PULSE), max_of(T_DHOLD, T_BUSY)), T_RD);
  localparam int PW     = $clog2(PH_MAX + 1);
  localparam int TW     = $clog2(T_TIMEOUT + 1);

  generate
    if (T_PULSE < PULSE_MIN || T_PULSE > PULSE_MAX) begin : g_bad_pulse
      $error("strobe length outside its allowed window"); // R4
    end
    if (T_SETUP < 1 || T_DHOLD < 1 || T_BUSY < 1 || T_RD < 1 || T_TIMEOUT < 2) begin : g_bad_phase
      $error("every phase needs at least one clock");
    end
  endgenerate

  logic          rdy_sync;
  logic          ph_load, ph_zero;
  logic [PW-1:0] ph_val;
  logic          tmo_load, tmo_dec, tmo_zero;
  logic [TW-1:0] tmo_val;

  eewr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) rdy_sync_i (
    .clk(clk), .rst(rst), .d(mem_rdy), .q(rdy_sync)
  );

  eewr_cnt #(.W(PW)) phase_cnt_i (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val),
    .dec(1'b1), .zero(ph_zero)
  );

  eewr_cnt #(.W(TW)) tmo_cnt_i (
    .clk(clk), .rst(rst), .load(tmo_load), .load_val(tmo_val),
    .dec(tmo_dec), .zero(tmo_zero)
  );

  eewr_fsm #(
    .AW(AW), .DW(DW), .PW(PW), .TW(TW),
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_DHOLD(T_DHOLD),
    .T_BUSY(T_BUSY), .T_RD(T_RD), .T_TIMEOUT(T_TIMEOUT)
  ) fsm_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_poll(req_poll), .req_ready(req_ready),
    .done_o(done_o), .timeout_o(timeout_o),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .rdy_sync(rdy_sync),
    .ph_load(ph_load), .ph_val(ph_val), .ph_zero(ph_zero),
    .tmo_load(tmo_load), .tmo_val(tmo_val), .tmo_dec(tmo_dec), .tmo_zero(tmo_zero)
  );

endmodule

// File: tb/eeprom_wr_seq_tb.sv
module eeprom_wr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int T_SETUP = 2;
  localparam int T_PULSE = 4;
  localparam int T_DHOLD = 2;
  localparam int T_BUSY = 3;
  localparam int T_RD = 2;
  localparam int T_TIMEOUT = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_poll = 1'b0;
  logic req_ready, done_o, timeout_o;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out, mem_dq_in;
  logic mem_rdy;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  // memory model
  logic [DW-1:0] mem [256];
  logic [DW-1:0] last_wr = '0;
  logic we_q = 1'b1;
  int busy = 0;
  int busy_len = 0;
  bit stuck = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wr_seq #(
    .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .PULSE_MIN(3), .PULSE_MAX(8),
    .T_PULSE(T_PULSE), .T_DHOLD(T_DHOLD), .T_BUSY(T_BUSY), .T_RD(T_RD),
    .T_TIMEOUT(T_TIMEOUT), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_poll(req_poll), .req_ready(req_ready),
    .done_o(done_o), .timeout_o(timeout_o), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_rdy(mem_rdy)
  );

  always @(posedge clk) begin
    we_q <= mem_we_n;
    if (mem_we_n && !we_q && !mem_ce_n) begin
      mem[mem_addr] <= mem_dq_out;
      last_wr <= mem_dq_out;
      busy <= busy_len;
    end else if (busy > 0 && !stuck) begin
      busy <= busy - 1;
    end
  end

  assign mem_rdy = (busy == 0);
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
                     ((busy != 0) ? {~last_wr[7], 7'h2A} : mem[mem_addr]) : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  // One transaction: drives the request, watches every cycle at the falling edge.
  task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit poll, input int blen, input bit hang,
                           input bit exp_tmo, input bit hold_valid);
    int setup_c = 0, pulse_c = 0, hold_c = 0, rd_c = 0, cont = 0;
    int addr_bad = 0, rdy_bad = 0, falls = 0, rise_cyc = -1, end_cyc = -1;
    bit fell = 0;
    logic prev_we = 1'b1;
    busy_len = blen;
    stuck = hang;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_poll = poll;
    for (int cyc = 1; cyc <= 1000; cyc++) begin
      @(negedge clk);
      if (!hold_valid) req_valid = 1'b0;
      if (!mem_ce_n && mem_we_n && mem_dq_oe && !fell) setup_c++;
      if (!mem_we_n) begin pulse_c++; fell = 1; end
      if (prev_we && !mem_we_n) falls++;
      if (fell && mem_we_n && rise_cyc < 0) rise_cyc = cyc;
      if (fell && mem_we_n && mem_dq_oe && !mem_ce_n) hold_c++;
      if (!mem_oe_n) rd_c++;
      if (mem_dq_oe && !mem_oe_n) cont++;
      if (mem_addr != a) addr_bad++;
      if (req_ready && !done_o && !timeout_o) rdy_bad++;
      prev_we = mem_we_n;
      if (done_o || timeout_o) begin
        end_cyc = cyc;
        break;
      end
    end
    req_valid = 1'b0;
    chk(end_cyc > 0, "R10 transaction ended", end_cyc, 1);
    chk(timeout_o == exp_tmo, "R10 timeout flag", timeout_o, exp_tmo);
    chk(done_o == !exp_tmo, "R8/R9 done flag", done_o, !exp_tmo);
    chk(setup_c == T_SETUP, "R3 setup clocks", setup_c, T_SETUP);
    chk(pulse_c == T_PULSE, "R4 strobe clocks", pulse_c, T_PULSE);
    chk(falls == 1, "R2 one strobe per request", falls, 1);
    chk(hold_c == T_DHOLD, "R5 hold clocks", hold_c, T_DHOLD);
    chk(addr_bad == 0, "R6 address changed", addr_bad, 0);
    chk(cont == 0, "R7 contention cycles", cont, 0);
    chk(rdy_bad == 0, "R2 ready during transaction", rdy_bad, 0);
    if (poll) begin
      chk(rd_c > 0 && (rd_c % T_RD) == 0, "R8 read clocks", rd_c, T_RD);
    end else begin
      chk(rd_c == 0, "R9 reads in line mode", rd_c, 0);
    end
    if (exp_tmo) begin
      chk(end_cyc - rise_cyc >= T_TIMEOUT && end_cyc - rise_cyc <= T_TIMEOUT + 12,
          "R10 timeout latency", end_cyc - rise_cyc, T_TIMEOUT);
    end else begin
      chk(end_cyc - rise_cyc >= blen, "R8/R9 done not before ready", end_cyc - rise_cyc, blen);
      chk(mem[a] == d, "R8/R9 stored byte", mem[a], d);
    end
    @(negedge clk);
    chk(!done_o && !timeout_o, "R11 pulse width", done_o | timeout_o, 0);
    chk(req_ready, "R2 ready after end", req_ready, 1);
    if (hang) begin
      stuck = 1'b0;
      repeat (blen + 4) @(negedge clk);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe, "R1 drive off", mem_dq_oe, 0);
    chk(req_ready && !done_o && !timeout_o, "R1 ready/pulses", {req_ready, done_o, timeout_o}, 4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    run_write(8'h12, 8'h5A, 1'b1, 20, 1'b0, 1'b0, 1'b0); // R8 bit7 = 0
    run_write(8'h34, 8'hA5, 1'b1, 35, 1'b0, 1'b0, 1'b0); // R8 bit7 = 1
    run_write(8'h56, 8'h3C, 1'b0, 25, 1'b0, 1'b0, 1'b0); // R9
    run_write(8'h78, 8'hC3, 1'b0, 1,  1'b0, 1'b0, 1'b0); // R9 short busy
    run_write(8'h9A, 8'h81, 1'b1, 10, 1'b1, 1'b1, 1'b0); // R10 poll hang
    run_write(8'hBC, 8'h7E, 1'b0, 10, 1'b1, 1'b1, 1'b0); // R10 line hang
    run_write(8'hDE, 8'h11, 1'b1, 15, 1'b0, 1'b0, 1'b1); // R2 valid held
    run_write(8'hDF, 8'hEE, 1'b0, 15, 1'b0, 1'b0, 1'b1); // R2 valid held
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule